// File: doc/BRIEF.md
# Clause-22 Management Slave with Emulated PHY Register File

This block sits on the station-management side of an Ethernet PHY model. It watches the management clock and data line, both oversampled by a fast system clock, and decodes each serial management frame: a run of idle ones, the start pattern, a two-bit operation code, a five-bit PHY address, a five-bit register number, a two-bit turnaround and sixteen data bits.

A write frame aimed at this PHY stores its sixteen data bits into a file of 32 sixteen-bit registers once the last bit has arrived. A read frame makes the block take over the shared data line after the turnaround and send the addressed register back, most significant bit first, changing the line only while the management clock is low. Register 1 is hard-wired to a status word that reports link up, autonegotiation done and ability, and speed and duplex capabilities. A read aimed at any other PHY address is answered with all ones.

Top module: `mdio_phy_slave`

## Requirements
- R1: After reset the output enable is low and every stored register (all indices except 1) reads back as 0x0000.
- R2: A frame is recognised only when its start 0 bit follows at least 32 consecutive 1 bits sampled on rising management-clock edges; a 0 arriving earlier clears the count, and the frame that follows it is ignored (no drive, no register change).
- R3: A write frame (opcode binary 01) to this PHY stores its 16 data bits, taken most significant bit first, and a later read returns exactly that value.
- R4: Register 1 always reads 0x782C (bits 14, 13, 12, 11, 5, 3 and 2 set); writes to it have no effect on what it reads.
- R5: A read frame (opcode binary 10) whose PHY address differs from the configured address (default 1) returns 0xFFFF.
- R6: A write frame to a different PHY address changes no register, and the output enable stays low for the whole frame.
- R7: The output enable is high only during the 16 data bits of a read frame; it rises after a falling management-clock edge and is low again once the frame's last rising edge has been processed.
- R8: The register number is the 5-bit field of the frame; all 31 stored registers hold their values independently.
- R9: After the 16th data bit the decoder waits for a new preamble, so frames sent back to back, each with exactly 32 preamble ones, are all decoded.
- R10: Frames with opcode binary 00 or 11 change no register and never drive the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the management clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock from the station manager |
| mdio_in | input | 1 | Management data as seen on the shared line |
| mdio_out | output | 1 | Data the slave drives during a read |
| mdio_oe | output | 1 | High while the slave owns the shared line |

## Verification
Directed frames cover the status register, the all-ones answer from a foreign address, a read-back of 0x8001 that exposes bit order, opcodes 00 and 11, and a frame preceded by only 31 idle ones, which separates a correct preamble counter from one that starts too early. A seeded random mix of reads and writes over all 32 register numbers and two PHY addresses, checked against a bench model of the register file, distinguishes index decoding errors and cross-register corruption. Every frame is sent with exactly 32 idle ones, so a decoder that fails to return to the idle state is caught on the next frame.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;
   typedef enum logic [2:0] {
      ST_PREAMBLE = 3'd0,
      ST_START    = 3'd1,
      ST_OPCODE   = 3'd2,
      ST_PHYADR   = 3'd3,
      ST_REGADR   = 3'd4,
      ST_TURN     = 3'd5,
      ST_DATA     = 3'd6
   } mdio_state_e;

   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam int         FIELD_W  = 5;
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc,
   input  logic mdio_in,
   output logic mdc_rise,
   output logic mdc_fall,
   output logic bit_q
);
   localparam int TOP = STAGES - 1;

   logic [TOP:0] clk_sh;
   logic [TOP:0] dat_sh;
   logic         clk_prev;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_sh <= '0;
               dat_sh <= '1;
            end else begin
               clk_sh <= mdc;
               dat_sh <= mdio_in;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_sh <= '0;
               dat_sh <= '1;
            end else begin
               clk_sh <= {clk_sh[TOP-1:0], mdc};
               dat_sh <= {dat_sh[TOP-1:0], mdio_in};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev <= 1'b0;
      else        clk_prev <= clk_sh[TOP];
   end

   assign mdc_rise = clk_sh[TOP] & ~clk_prev;
   assign mdc_fall = ~clk_sh[TOP] & clk_prev;
   assign bit_q    = dat_sh[TOP];
endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs #(
   parameter int                 DATA_W      = 16,
   parameter int                 IDX_W       = 5,
   parameter int                 STATUS_IDX  = 1,
   parameter logic [DATA_W-1:0]  STATUS_WORD = 16'h782C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   localparam int NUM = 1 << IDX_W;

   logic [NUM-1:0][DATA_W-1:0] word;

   generate
      for (genvar g = 0; g < NUM; g++) begin : g_reg
         if (g == STATUS_IDX) begin : g_fixed
            assign word[g] = STATUS_WORD;
         end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                  q <= '0;
               else if (wr_en && (wr_idx == IDX_W'(g)))     q <= wr_data;
            end
            assign word[g] = q;
         end
      end
   endgenerate

   assign rd_data = word[rd_idx];
endmodule

// File: rtl/mdio_frame_decoder.sv
module mdio_frame_decoder
   import mdio_phy_pkg::*;
#(
   parameter int          DATA_W       = 16,
   parameter int          PREAMBLE_LEN = 32,
   parameter logic [4:0]  PHY_ADDR     = 5'd1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mdc_rise,
   input  logic                mdc_fall,
   input  logic                bit_i,
   input  logic [DATA_W-1:0]   rd_data,
   output logic [FIELD_W-1:0]  reg_idx,
   output logic                wr_en,
   output logic [DATA_W-1:0]   wr_data,
   output logic                mdio_out,
   output logic                mdio_oe,
   output mdio_state_e         state,
   output logic                rd_mode,
   output logic                pre_full,
   output logic                last_bit
);
   localparam int PRE_W = $clog2(PREAMBLE_LEN + 1);
   localparam int CNT_W = $clog2((DATA_W > FIELD_W) ? DATA_W : FIELD_W);

   mdio_state_e          state_q;
   logic [PRE_W-1:0]     pre_cnt_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [1:0]           opc_q;
   logic [FIELD_W-1:0]   phy_q;
   logic [FIELD_W-1:0]   reg_q;
   logic [DATA_W-1:0]    shift_q;
   logic [DATA_W-1:0]    tx_q;
   logic                 rd_mode_q;
   logic                 oe_q;
   logic                 out_q;
   logic                 wr_en_q;
   logic [DATA_W-1:0]    wr_data_q;
   logic                 hit;

   assign pre_full = (pre_cnt_q == PRE_W'(PREAMBLE_LEN));
   assign hit      = (phy_q == PHY_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_PREAMBLE;
         pre_cnt_q <= '0;
         cnt_q     <= '0;
         opc_q     <= '0;
         phy_q     <= '0;
         reg_q     <= '0;
         shift_q   <= '0;
         tx_q      <= '0;
         rd_mode_q <= 1'b0;
         oe_q      <= 1'b0;
         out_q     <= 1'b0;
         wr_en_q   <= 1'b0;
         wr_data_q <= '0;
      end else begin
         wr_en_q <= 1'b0;
         if (mdc_rise) begin
            case (state_q)
               ST_PREAMBLE: begin
                  if (bit_i) begin
                     if (!pre_full) pre_cnt_q <= pre_cnt_q + 1'b1;
                  end else if (pre_full) begin
                     state_q   <= ST_START;
                     pre_cnt_q <= '0;
                  end else begin
                     pre_cnt_q <= '0;
                  end
               end
               ST_START: begin
                  state_q <= ST_OPCODE;
                  cnt_q   <= '0;
               end
               ST_OPCODE: begin
                  opc_q <= {opc_q[0], bit_i};
                  if (cnt_q == CNT_W'(1)) begin
                     state_q <= ST_PHYADR;
                     cnt_q   <= '0;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               ST_PHYADR: begin
                  phy_q <= {phy_q[FIELD_W-2:0], bit_i};
                  if (cnt_q == CNT_W'(FIELD_W - 1)) begin
                     state_q <= ST_REGADR;
                     cnt_q   <= '0;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               ST_REGADR: begin
                  reg_q <= {reg_q[FIELD_W-2:0], bit_i};
                  if (cnt_q == CNT_W'(FIELD_W - 1)) begin
                     state_q <= ST_TURN;
                     cnt_q   <= '0;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               ST_TURN: begin
                  if (cnt_q == CNT_W'(1)) begin
                     state_q   <= ST_DATA;
                     cnt_q     <= '0;
                     rd_mode_q <= (opc_q == OP_READ);
                     tx_q      <= hit ? rd_data : '1;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               ST_DATA: begin
                  shift_q <= {shift_q[DATA_W-2:0], bit_i};
                  if (cnt_q == CNT_W'(DATA_W - 1)) begin
                     state_q   <= ST_PREAMBLE;
                     cnt_q     <= '0;
                     rd_mode_q <= 1'b0;
                     oe_q      <= 1'b0;
                     if ((opc_q == OP_WRITE) && hit) begin
                        wr_en_q   <= 1'b1;
                        wr_data_q <= {shift_q[DATA_W-2:0], bit_i};
                     end
                  end else cnt_q <= cnt_q + 1'b1;
               end
               default: state_q <= ST_PREAMBLE;
            endcase
         end else if (mdc_fall && (state_q == ST_DATA) && rd_mode_q) begin
            oe_q  <= 1'b1;
            out_q <= tx_q[DATA_W-1];
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign reg_idx  = reg_q;
   assign wr_en    = wr_en_q;
   assign wr_data  = wr_data_q;
   assign mdio_out = out_q;
   assign mdio_oe  = oe_q;
   assign state    = state_q;
   assign rd_mode  = rd_mode_q;
   assign last_bit = (state_q == ST_DATA) && (cnt_q == CNT_W'(DATA_W - 1));
endmodule

// File: rtl/mdio_phy_slave.sv
module mdio_phy_slave
   import mdio_phy_pkg::*;
#(
   parameter logic [4:0]          PHY_ADDR     = 5'd1,
   parameter int                  DATA_W       = 16,
   parameter int                  PREAMBLE_LEN = 32,
   parameter int                  SYNC_STAGES  = 2,
   parameter int                  STATUS_IDX   = 1,
   parameter logic [DATA_W-1:0]   STATUS_WORD  = 16'h782C
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc,
   input  logic mdio_in,
   output logic mdio_out,
   output logic mdio_oe
);
   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("mdio_phy_slave: data field must be 16 bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mdio_phy_slave: synchroniser needs at least two stages");
      end
      if (PREAMBLE_LEN < 1) begin : g_bad_pre
         $error("mdio_phy_slave: preamble length must be positive");
      end
      if ((STATUS_IDX < 0) || (STATUS_IDX >= (1 << FIELD_W))) begin : g_bad_stat
         $error("mdio_phy_slave: status register index out of range");
      end
   endgenerate

   logic                mdc_rise;
   logic                mdc_fall;
   logic                bit_s;
   logic [FIELD_W-1:0]  reg_idx;
   logic                wr_en;
   logic [DATA_W-1:0]   wr_data;
   logic [DATA_W-1:0]   rd_data;
   mdio_state_e         dec_state;
   logic                dec_rd_mode;
   logic                dec_pre_full;
   logic                dec_last_bit;

   mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdc      (mdc),
      .mdio_in  (mdio_in),
      .mdc_rise (mdc_rise),
      .mdc_fall (mdc_fall),
      .bit_q    (bit_s)
   );

   mdio_frame_decoder #(
      .DATA_W       (DATA_W),
      .PREAMBLE_LEN (PREAMBLE_LEN),
      .PHY_ADDR     (PHY_ADDR)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdc_rise (mdc_rise),
      .mdc_fall (mdc_fall),
      .bit_i    (bit_s),
      .rd_data  (rd_data),
      .reg_idx  (reg_idx),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .mdio_out (mdio_out),
      .mdio_oe  (mdio_oe),
      .state    (dec_state),
      .rd_mode  (dec_rd_mode),
      .pre_full (dec_pre_full),
      .last_bit (dec_last_bit)
   );

   mdio_phy_regs #(
      .DATA_W      (DATA_W),
      .IDX_W       (FIELD_W),
      .STATUS_IDX  (STATUS_IDX),
      .STATUS_WORD (STATUS_WORD)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (reg_idx),
      .wr_data (wr_data),
      .rd_idx  (reg_idx),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/mdio_phy_slave_chk.sv
module mdio_phy_slave_chk
   import mdio_phy_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        mdio_oe,
   input logic        mdio_out,
   input logic        mdc_rise,
   input logic        mdc_fall,
   input mdio_state_e st,
   input logic        rd_mode,
   input logic        pre_full,
   input logic        last_bit
);
   // R7: the line is owned only inside the data phase of a read
   a_r7_oe_in_read_data: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> ((st == ST_DATA) && rd_mode));

   // R6 / R10: without a read in progress the slave never drives
   a_r6_quiet_without_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_mode |-> !mdio_oe);

   // R7: ownership is taken right after a falling management-clock edge
   a_r7_oe_rises_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> $past(mdc_fall));

   // R3: driven data changes only after a falling edge
   a_r3_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_out != $past(mdio_out)) |-> $past(mdc_fall));

   // R9: the last data bit returns the decoder to idle and releases the line
   a_r9_back_to_preamble: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && mdc_rise) |=> ((st == ST_PREAMBLE) && !mdio_oe));

   // R2: a frame begins only after a full preamble
   a_r2_start_needs_preamble: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_START) && ($past(st) == ST_PREAMBLE)) |-> $past(pre_full));
endmodule

bind mdio_phy_slave mdio_phy_slave_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mdio_oe  (mdio_oe),
   .mdio_out (mdio_out),
   .mdc_rise (mdc_rise),
   .mdc_fall (mdc_fall),
   .st       (dec_state),
   .rd_mode  (dec_rd_mode),
   .pre_full (dec_pre_full),
   .last_bit (dec_last_bit)
);

// File: tb/mdio_phy_slave_bench.sv
`timescale 1ns/1ps
module mdio_phy_slave_bench;
   localparam int HALF = 6;
   localparam logic [4:0] MY_ADDR = 5'd1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mdc = 1'b0;
   logic mdio_in = 1'b1;
   logic mdio_out;
   logic mdio_oe;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   bit oe_seen = 1'b0;
   logic s_out;
   logic [15:0] model [32];

   always #2.5 clk = ~clk;

   mdio_phy_slave u_mdio_phy_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdc      (mdc),
      .mdio_in  (mdio_in),
      .mdio_out (mdio_out),
      .mdio_oe  (mdio_oe)
   );

   always @(negedge clk) if (mdio_oe === 1'b1) oe_seen = 1'b1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] expect_rd(input logic [4:0] phy, input logic [4:0] rg);
      if (phy != MY_ADDR) return 16'hFFFF;
      if (rg == 5'd1)     return 16'h782C;
      return model[rg];
   endfunction

   task automatic mbit(input logic b);
      @(negedge clk);
      mdc = 1'b0;
      mdio_in = b;
      repeat (HALF) @(negedge clk);
      s_out = mdio_out;
      mdc = 1'b1;
      repeat (HALF - 1) @(negedge clk);
   endtask

   task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input int pre, output logic [15:0] rd);
      rd = '0;
      for (int i = 0; i < pre; i++) mbit(1'b1);
      mbit(1'b0);
      mbit(1'b1);
      for (int i = 1; i >= 0; i--) mbit(op[i]);
      for (int i = 4; i >= 0; i--) mbit(phy[i]);
      for (int i = 4; i >= 0; i--) mbit(rg[i]);
      if (op == 2'b10) begin mbit(1'b1); mbit(1'b1); end
      else             begin mbit(1'b1); mbit(1'b0); end
      for (int i = 15; i >= 0; i--) begin
         if (op == 2'b10) begin mbit(1'b1); rd[i] = s_out; end
         else mbit(wd[i]);
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic do_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
      logic [15:0] dummy;
      frame(2'b01, phy, rg, wd, 32, dummy);
      if (phy == MY_ADDR && rg != 5'd1) model[rg] = wd;
   endtask

   task automatic do_read(input string req, input logic [4:0] phy, input logic [4:0] rg);
      logic [15:0] got;
      frame(2'b10, phy, rg, 16'h0, 32, got);
      chk(req, {16'h0, got}, {16'h0, expect_rd(phy, rg)});
      chk("R7 released after read", {31'h0, mdio_oe}, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] got;
      void'($urandom(32'h5EED1));
      for (int i = 0; i < 32; i++) model[i] = 16'h0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: reset state
      chk("R1 oe after reset", {31'h0, mdio_oe}, 32'h0);
      do_read("R1 reg0 after reset", MY_ADDR, 5'd0);
      do_read("R1 reg31 after reset", MY_ADDR, 5'd31);

      // R4: fixed status word, writes have no effect
      do_read("R4 status word", MY_ADDR, 5'd1);
      do_write(MY_ADDR, 5'd1, 16'h0000);
      do_read("R4 status after write", MY_ADDR, 5'd1);

      // R3: bit order and plain write/read
      do_write(MY_ADDR, 5'd4, 16'h8001);
      do_read("R3 msb-first 8001", MY_ADDR, 5'd4);
      do_write(MY_ADDR, 5'd0, 16'hA5C3);
      do_read("R3 reg0 A5C3", MY_ADDR, 5'd0);

      // R5: foreign address read
      do_read("R5 foreign read", 5'd2, 5'd0);

      // R6: foreign address write ignored, line never driven
      oe_seen = 1'b0;
      do_write(5'd9, 5'd0, 16'h1111);
      chk("R6 no drive on foreign write", {31'h0, oe_seen}, 32'h0);
      do_read("R6 reg0 unchanged", MY_ADDR, 5'd0);

      // R10: opcodes 00 and 11
      oe_seen = 1'b0;
      frame(2'b11, MY_ADDR, 5'd0, 16'h2222, 32, got);
      frame(2'b00, MY_ADDR, 5'd0, 16'h3333, 32, got);
      chk("R10 no drive on unused opcodes", {31'h0, oe_seen}, 32'h0);
      do_read("R10 reg0 unchanged", MY_ADDR, 5'd0);

      // R2: only 31 idle ones before a write, then a proper read
      oe_seen = 1'b0;
      frame(2'b01, MY_ADDR, 5'd7, 16'h1234, 31, got);
      chk("R2 short preamble no drive", {31'h0, oe_seen}, 32'h0);
      do_read("R2 short preamble write dropped", MY_ADDR, 5'd7);
      // R2: a longer preamble is also accepted
      frame(2'b10, MY_ADDR, 5'd4, 16'h0, 45, got);
      chk("R2 long preamble read", {16'h0, got}, {16'h0, model[4]});

      // R8 / R9: seeded random mix, back to back with 32-bit preambles
      for (int n = 0; n < 60; n++) begin
         logic [4:0] rg;
         logic [4:0] ph;
         rg = 5'($urandom_range(0, 31));
         ph = ($urandom_range(0, 7) == 0) ? 5'd2 : MY_ADDR;
         if ($urandom_range(0, 1) == 0) do_write(ph, rg, 16'($urandom));
         else do_read("R8 R9 random read", ph, rg);
      end
      // R8: sweep all indices
      for (int r = 0; r < 32; r++) do_read("R8 sweep", MY_ADDR, 5'(r));

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule